// File: doc/BRIEF.md
# Remote Defect Persistence Filter

This block watches the path overhead of one low-order tributary and filters the far-end defect indications it carries. Once per multiframe a valid strobe brings in the received V5 byte, and the Z7 byte with it. From these the block pulls out the remote failure indication (RFI) and the remote defect indication (RDI). RDI comes either as one bit or, in enhanced mode, as a 3-bit code. A received value becomes the accepted state only after it has come in unchanged on a programmable number of consecutive valid multiframes. Single frame hits therefore never reach the alarm logic.

Each accepted state has a sticky change flag. A write-one-to-clear pulse clears the flag. Any flag whose mask bit is low raises the interrupt line. In byte-synchronous DS1 operation, an accepted RFI also drives a remote alarm request toward the downstream framer. The framing itself is done elsewhere.

Top module: `remote_defect_filter`

## Requirements
- R1: After reset, all accepted states, change flags, `irq` and `framerRai` are 0.
- R2: The RFI value is V5 bit 4, counting bits 1 to 8 from the MSB (mask 0x10). It is accepted once it has been received on N consecutive valid frames, where N is `normThresh`. RFI is filtered in both RDI modes.
- R3: With `rdiOneBit`=1, the RDI value is V5 bit 8 (mask 0x01). It is accepted after N consecutive valid frames, where N is `normThresh`.
- R4: A received value that differs from the previous valid frame's value restarts the run at 1. Cycles with `rxValid`=0 neither advance nor break a run, and they leave every accepted state unchanged.
- R5: With `rdiOneBit`=0, the enhanced code is {V5 bit 8, Z7 bit 6, Z7 bit 7}, with the MSB first (masks 0x01, 0x04, 0x02). It is accepted after `enhThresh` consecutive identical codes. Z7 bit 5 and all other bits have no effect.
- R6: The RDI filter that the mode does not select holds its accepted state. It also drops its run, so after a mode switch a full run is needed before the state can change.
- R7: Each change of an accepted state sets that state's change flag. The flag stays set until its clear input is pulsed. If a set and a clear fall in the same cycle, the set wins.
- R8: `irq` is high exactly when at least one change flag is set and its mask bit is 0.
- R9: `framerRai` is 1 exactly when `ds1ByteSync`=1 and the accepted RFI is 1.
- R10: A threshold of 0 acts as 1. A threshold of 15 needs 15 consecutive frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | One multiframe's overhead bytes are present |
| rxV5 | input | 8 | Received V5 byte |
| rxZ7 | input | 8 | Received Z7 byte |
| rdiOneBit | input | 1 | 1: single-bit RDI; 0: enhanced 3-bit RDI |
| ds1ByteSync | input | 1 | Byte-synchronous DS1 operation |
| normThresh | input | 4 | Persistence count for RFI and single-bit RDI |
| enhThresh | input | 4 | Persistence count for the enhanced RDI code |
| maskRfi | input | 1 | Masks the RFI change flag from the interrupt |
| maskRdi | input | 1 | Masks the RDI change flag from the interrupt |
| maskErdi | input | 1 | Masks the enhanced RDI change flag from the interrupt |
| clrRfiChg | input | 1 | Write-one-to-clear for the RFI change flag |
| clrRdiChg | input | 1 | Write-one-to-clear for the RDI change flag |
| clrErdiChg | input | 1 | Write-one-to-clear for the enhanced RDI change flag |
| rfiState | output | 1 | Accepted RFI |
| rdiState | output | 1 | Accepted single-bit RDI |
| erdiState | output | 3 | Accepted enhanced RDI code |
| rfiChg | output | 1 | Sticky RFI change flag |
| rdiChg | output | 1 | Sticky RDI change flag |
| erdiChg | output | 1 | Sticky enhanced RDI change flag |
| irq | output | 1 | Interrupt |
| framerRai | output | 1 | Remote alarm request to the DS1 framer |

## Verification
An acceptance that sets a change flag can fall in the same cycle as a software clear of that flag. The bench provokes this by pulsing the RFI clear on exactly the frame that completes an RFI run. It then expects the flag, and `irq`, to stay high, and a later clear on its own to drop them. It also interleaves invalid cycles inside runs, to show they neither count nor restart a run. Around mode switches, it confirms that the deselected filter keeps its accepted state.

// File: rtl/rdp_pkg.sv
package rdp_pkg;
  localparam int NUM_CH  = 3;
  localparam int CH_RFI  = 0;
  localparam int CH_RDI  = 1;
  localparam int CH_ERDI = 2;
  localparam int ERDI_W  = 3;

  // control -> datapath
  typedef struct packed {
    logic [NUM_CH-1:0] capture;  // remember this frame's value
    logic [NUM_CH-1:0] accept;   // load the value as accepted state
  } rdpStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic [NUM_CH-1:0] sameAsLast;  // value equals previous valid frame
    logic [NUM_CH-1:0] differsAcc;  // value differs from accepted state
  } rdpCmp_t;
endpackage

// File: rtl/rdp_track.sv
module rdp_track #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] code,
  input  logic         capture,
  input  logic         accept,
  input  logic         clr,
  output logic         sameAsLast,
  output logic         differsAcc,
  output logic [W-1:0] state,
  output logic         chg
);
  logic [W-1:0] lastCode;

  assign sameAsLast = (code == lastCode);
  assign differsAcc = (code != state);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastCode <= '0;
      state    <= '0;
      chg      <= 1'b0;
    end else begin
      if (capture) lastCode <= code;
      if (accept)  state    <= code;
      if (accept)   chg <= 1'b1;  // set wins over clear
      else if (clr) chg <= 1'b0;
    end
  end
endmodule

// File: rtl/rdp_datapath.sv
module rdp_datapath
  import rdp_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [7:0]             rxV5,
  input  logic [7:0]             rxZ7,
  input  rdpStrobe_t             strobe,
  input  logic [NUM_CH-1:0]      clrVec,
  input  logic [NUM_CH-1:0]      maskVec,
  output rdpCmp_t                cmp,
  output logic                   rfiState,
  output logic                   rdiState,
  output logic [ERDI_W-1:0]      erdiState,
  output logic [NUM_CH-1:0]      chgVec,
  output logic                   irq
);
  logic [NUM_CH-1:0] sameV, diffV;

  // bit n of the overhead byte (1 = MSB) sits at index 8-n
  logic              rfiCode, rdiCode;
  logic [ERDI_W-1:0] erdiCode;
  assign rfiCode  = rxV5[4];
  assign rdiCode  = rxV5[0];
  assign erdiCode = {rxV5[0], rxZ7[2], rxZ7[1]};

  rdp_track #(.W(1)) u_rfi (
    .clk(clk), .rstN(rstN), .code(rfiCode),
    .capture(strobe.capture[CH_RFI]), .accept(strobe.accept[CH_RFI]),
    .clr(clrVec[CH_RFI]), .sameAsLast(sameV[CH_RFI]), .differsAcc(diffV[CH_RFI]),
    .state(rfiState), .chg(chgVec[CH_RFI]));

  rdp_track #(.W(1)) u_rdi (
    .clk(clk), .rstN(rstN), .code(rdiCode),
    .capture(strobe.capture[CH_RDI]), .accept(strobe.accept[CH_RDI]),
    .clr(clrVec[CH_RDI]), .sameAsLast(sameV[CH_RDI]), .differsAcc(diffV[CH_RDI]),
    .state(rdiState), .chg(chgVec[CH_RDI]));

  rdp_track #(.W(ERDI_W)) u_erdi (
    .clk(clk), .rstN(rstN), .code(erdiCode),
    .capture(strobe.capture[CH_ERDI]), .accept(strobe.accept[CH_ERDI]),
    .clr(clrVec[CH_ERDI]), .sameAsLast(sameV[CH_ERDI]), .differsAcc(diffV[CH_ERDI]),
    .state(erdiState), .chg(chgVec[CH_ERDI]));

  assign cmp = '{sameAsLast: sameV, differsAcc: diffV};
  assign irq = |(chgVec & ~maskVec);
endmodule

// File: rtl/rdp_ctrl.sv
module rdp_ctrl
  import rdp_pkg::*;
#(
  parameter int THR_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxValid,
  input  logic             rdiOneBit,
  input  logic [THR_W-1:0] normThr,
  input  logic [THR_W-1:0] enhThr,
  input  rdpCmp_t          cmp,
  output rdpStrobe_t       strobe
);
  localparam logic [THR_W-1:0] CNT_MAX = '1;
  localparam logic [THR_W-1:0] ONE     = THR_W'(1);

  logic [NUM_CH-1:0] capV, accV;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [THR_W-1:0] cnt, nextCnt, thrSel, effThr;
    logic             active;

    if (c == CH_RFI) begin : g_rfi
      assign active = 1'b1;
      assign thrSel = normThr;
    end else if (c == CH_RDI) begin : g_rdi
      assign active = rdiOneBit;
      assign thrSel = normThr;
    end else begin : g_erdi
      assign active = !rdiOneBit;
      assign thrSel = enhThr;
    end

    assign effThr = (thrSel == '0) ? ONE : thrSel;

    always_comb begin
      if (cnt != '0 && cmp.sameAsLast[c])
        nextCnt = (cnt == CNT_MAX) ? cnt : cnt + ONE;
      else
        nextCnt = ONE;
    end

    always_ff @(posedge clk) begin
      if (!rstN)        cnt <= '0;
      else if (!active) cnt <= '0;
      else if (rxValid) cnt <= nextCnt;
    end

    assign capV[c] = rxValid & active;
    assign accV[c] = rxValid & active & (nextCnt >= effThr) & cmp.differsAcc[c];
  end

  assign strobe = '{capture: capV, accept: accV};
endmodule

// File: rtl/remote_defect_filter.sv
module remote_defect_filter
  import rdp_pkg::*;
#(
  parameter int THR_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxValid,
  input  logic [7:0]       rxV5,
  input  logic [7:0]       rxZ7,
  input  logic             rdiOneBit,
  input  logic             ds1ByteSync,
  input  logic [THR_W-1:0] normThresh,
  input  logic [THR_W-1:0] enhThresh,
  input  logic             maskRfi,
  input  logic             maskRdi,
  input  logic             maskErdi,
  input  logic             clrRfiChg,
  input  logic             clrRdiChg,
  input  logic             clrErdiChg,
  output logic             rfiState,
  output logic             rdiState,
  output logic [2:0]       erdiState,
  output logic             rfiChg,
  output logic             rdiChg,
  output logic             erdiChg,
  output logic             irq,
  output logic             framerRai
);
  rdpStrobe_t        strobe;
  rdpCmp_t           cmp;
  logic [NUM_CH-1:0] chgVec;

  rdp_ctrl #(.THR_W(THR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rdiOneBit(rdiOneBit),
    .normThr(normThresh), .enhThr(enhThresh), .cmp(cmp), .strobe(strobe));

  rdp_datapath u_dp (
    .clk(clk), .rstN(rstN), .rxV5(rxV5), .rxZ7(rxZ7), .strobe(strobe),
    .clrVec({clrErdiChg, clrRdiChg, clrRfiChg}),
    .maskVec({maskErdi, maskRdi, maskRfi}),
    .cmp(cmp), .rfiState(rfiState), .rdiState(rdiState), .erdiState(erdiState),
    .chgVec(chgVec), .irq(irq));

  assign rfiChg    = chgVec[CH_RFI];
  assign rdiChg    = chgVec[CH_RDI];
  assign erdiChg   = chgVec[CH_ERDI];
  assign framerRai = ds1ByteSync & rfiState;
endmodule

// File: rtl/remote_defect_filter_chk.sv
module remote_defect_filter_chk (
  input logic       clk,
  input logic       rstN,
  input logic       rxValid,
  input logic       rdiOneBit,
  input logic       ds1ByteSync,
  input logic       maskRfi,
  input logic       maskRdi,
  input logic       maskErdi,
  input logic       clrRfiChg,
  input logic       rfiState,
  input logic       rdiState,
  input logic [2:0] erdiState,
  input logic       rfiChg,
  input logic       rdiChg,
  input logic       erdiChg,
  input logic       irq,
  input logic       framerRai
);
  p_idle_holds_r4: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |=> ($stable(rfiState) && $stable(rdiState) && $stable(erdiState)));

  p_rdi_frozen_r6: assert property (@(posedge clk) disable iff (!rstN)
    !rdiOneBit |=> $stable(rdiState));

  p_erdi_frozen_r6: assert property (@(posedge clk) disable iff (!rstN)
    rdiOneBit |=> $stable(erdiState));

  p_rfi_change_flags_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rfiState) |-> rfiChg);

  p_rdi_change_flags_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rdiState) |-> rdiChg);

  p_erdi_change_flags_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(erdiState) |-> erdiChg);

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rfiChg && !clrRfiChg) |=> rfiChg);

  p_all_masked_r8: assert property (@(posedge clk) disable iff (!rstN)
    (maskRfi && maskRdi && maskErdi) |-> !irq);

  p_no_flag_no_irq_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!rfiChg && !rdiChg && !erdiChg) |-> !irq);

  p_rai_needs_ds1_r9: assert property (@(posedge clk) disable iff (!rstN)
    !ds1ByteSync |-> !framerRai);

  p_rai_follows_rfi_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ds1ByteSync && rfiState) |-> framerRai);
endmodule

bind remote_defect_filter remote_defect_filter_chk u_chk (
  .clk(clk), .rstN(rstN), .rxValid(rxValid), .rdiOneBit(rdiOneBit),
  .ds1ByteSync(ds1ByteSync), .maskRfi(maskRfi), .maskRdi(maskRdi),
  .maskErdi(maskErdi), .clrRfiChg(clrRfiChg), .rfiState(rfiState),
  .rdiState(rdiState), .erdiState(erdiState), .rfiChg(rfiChg),
  .rdiChg(rdiChg), .erdiChg(erdiChg), .irq(irq), .framerRai(framerRai));

// File: tb/remote_defect_filter_bench.sv
module remote_defect_filter_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxValid = 1'b0;
  logic [7:0] rxV5 = '0, rxZ7 = '0;
  logic       rdiOneBit = 1'b1, ds1ByteSync = 1'b0;
  logic [3:0] normThresh = 4'd3, enhThresh = 4'd2;
  logic       maskRfi = 1'b0, maskRdi = 1'b0, maskErdi = 1'b0;
  logic       clrRfiChg = 1'b0, clrRdiChg = 1'b0, clrErdiChg = 1'b0;
  logic       rfiState, rdiState, rfiChg, rdiChg, erdiChg, irq, framerRai;
  logic [2:0] erdiState;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  remote_defect_filter u_remote_defect_filter (.*);

  typedef struct {
    logic [9:0] vec;
    string      tag;
  } expItem_t;
  expItem_t expQ[$];
  event itemReady;

  // requirement model
  int   mLast[3], mCnt[3], mAcc[3];
  logic mChg[3];

  function automatic logic [9:0] actualVec();
    return {rfiState, rdiState, erdiState, rfiChg, rdiChg, erdiChg, irq, framerRai};
  endfunction

  function automatic logic [9:0] modelVec();
    logic irqE;
    irqE = (mChg[0] && !maskRfi) || (mChg[1] && !maskRdi) || (mChg[2] && !maskErdi);
    return {mAcc[0][0], mAcc[1][0], mAcc[2][2:0], mChg[0], mChg[1], mChg[2],
            irqE, ds1ByteSync && mAcc[0][0]};
  endfunction

  task automatic frame(input logic v, input logic [7:0] v5, input logic [7:0] z7,
                       input logic [2:0] clr, input string tag);
    int   codes[3];
    logic act[3];
    int   thr[3];
    logic setF[3];
    rxValid = v; rxV5 = v5; rxZ7 = z7;
    {clrErdiChg, clrRdiChg, clrRfiChg} = clr;
    codes[0] = v5[4];
    codes[1] = v5[0];
    codes[2] = {v5[0], z7[2], z7[1]};
    act[0] = 1'b1; act[1] = rdiOneBit; act[2] = !rdiOneBit;
    thr[0] = (normThresh == 0) ? 1 : normThresh;
    thr[1] = thr[0];
    thr[2] = (enhThresh == 0) ? 1 : enhThresh;
    for (int c = 0; c < 3; c++) begin
      setF[c] = 1'b0;
      if (!act[c]) mCnt[c] = 0;
      else if (v) begin
        if (mCnt[c] != 0 && codes[c] == mLast[c]) mCnt[c] = (mCnt[c] < 15) ? mCnt[c] + 1 : 15;
        else mCnt[c] = 1;
        mLast[c] = codes[c];
        if (mCnt[c] >= thr[c] && codes[c] != mAcc[c]) begin
          mAcc[c] = codes[c];
          setF[c] = 1'b1;
        end
      end
      if (setF[c]) mChg[c] = 1'b1;
      else if (clr[c]) mChg[c] = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    expQ.push_back('{vec: modelVec(), tag: tag});
    -> itemReady;
    #1;
    {clrErdiChg, clrRdiChg, clrRfiChg} = 3'b000;
    rxValid = 1'b0;
  endtask

  task automatic runOf(input int n, input logic [7:0] v5, input logic [7:0] z7, input string tag);
    for (int i = 0; i < n; i++) frame(1'b1, v5, z7, 3'b000, tag);
  endtask

  initial begin : monitor
    expItem_t it;
    forever begin
      @(itemReady);
      while (expQ.size() > 0) begin
        it = expQ.pop_front();
        checks++;
        if (actualVec() !== it.vec) begin
          errors++;
          $display("FAIL %s: actual=%b expected=%b (rfi rdi erdi[3] chg[3] irq rai)",
                   it.tag, actualVec(), it.vec);
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stimulus
    for (int c = 0; c < 3; c++) begin mLast[c] = 0; mCnt[c] = 0; mAcc[c] = 0; mChg[c] = 1'b0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    checks++;
    if (actualVec() !== 10'b0) begin
      errors++;
      $display("FAIL R1: actual=%b expected=%b", actualVec(), 10'b0);
    end

    // R2: RFI accepted after three frames
    runOf(3, 8'h10, 8'h00, "R2 rfi set");
    runOf(3, 8'h00, 8'h00, "R2 rfi clear");
    // R4: idle cycles inside a run, then a broken run
    frame(1'b1, 8'h10, 8'h00, 3'b000, "R4 run1");
    frame(1'b1, 8'h10, 8'h00, 3'b000, "R4 run2");
    frame(1'b0, 8'h00, 8'h00, 3'b000, "R4 idle no break");
    frame(1'b1, 8'h10, 8'h00, 3'b000, "R4 run3 accepts");
    frame(1'b1, 8'h00, 8'h00, 3'b000, "R4 zero1");
    frame(1'b1, 8'h00, 8'h00, 3'b000, "R4 zero2");
    frame(1'b1, 8'h10, 8'h00, 3'b000, "R4 restart");
    runOf(2, 8'h00, 8'h00, "R4 short run");
    frame(1'b1, 8'h00, 8'h00, 3'b000, "R4 full run");
    // R3: single-bit RDI
    runOf(3, 8'h01, 8'h00, "R3 rdi set");
    runOf(3, 8'h00, 8'h00, "R3 rdi clear");
    // R7: clear, then collision of set and clear
    frame(1'b0, 8'h00, 8'h00, 3'b111, "R7 clear all");
    runOf(2, 8'h10, 8'h00, "R7 pre");
    frame(1'b1, 8'h10, 8'h00, 3'b001, "R7 set beats clear");
    frame(1'b0, 8'h00, 8'h00, 3'b000, "R7 sticky");
    // R8: masking
    maskRfi = 1'b1;
    frame(1'b0, 8'h00, 8'h00, 3'b000, "R8 masked");
    maskRfi = 1'b0;
    frame(1'b0, 8'h00, 8'h00, 3'b000, "R8 unmasked");
    frame(1'b0, 8'h00, 8'h00, 3'b001, "R7 clear alone");
    // R9: framer alarm
    ds1ByteSync = 1'b1;
    frame(1'b0, 8'h00, 8'h00, 3'b000, "R9 rai on");
    runOf(3, 8'h00, 8'h00, "R9 rai follows rfi");
    ds1ByteSync = 1'b0;
    frame(1'b0, 8'h00, 8'h00, 3'b111, "R7 clear all");
    // R5: enhanced code with Z7 bit 5 and spare bits toggling
    rdiOneBit = 1'b0;
    frame(1'b1, 8'h01, 8'h06, 3'b000, "R5 code7 a");
    frame(1'b1, 8'h01, 8'h0E, 3'b000, "R5 code7 z7 bit5 ignored");
    frame(1'b1, 8'h01, 8'hF7, 3'b000, "R5 spare bits ignored");
    frame(1'b1, 8'h00, 8'h04, 3'b000, "R5 code2 once");
    frame(1'b1, 8'h00, 8'h02, 3'b000, "R5 code1 a");
    frame(1'b1, 8'h00, 8'h0A, 3'b000, "R5 code1 b");
    // R6: single-bit RDI frozen in enhanced mode
    runOf(4, 8'h01, 8'h00, "R6 rdi frozen");
    rdiOneBit = 1'b1;
    frame(1'b1, 8'h01, 8'h00, 3'b000, "R6 rdi rearm1");
    frame(1'b1, 8'h01, 8'h00, 3'b000, "R6 rdi rearm2");
    frame(1'b1, 8'h01, 8'h06, 3'b000, "R6 rdi set erdi frozen");
    rdiOneBit = 1'b0;
    frame(1'b1, 8'h00, 8'h00, 3'b000, "R6 erdi rearm1");
    rdiOneBit = 1'b1;
    frame(1'b1, 8'h00, 8'h00, 3'b000, "R6 erdi run dropped");
    // R10: threshold limits
    normThresh = 4'd0;
    frame(1'b1, 8'h10, 8'h00, 3'b000, "R10 thr0 single frame");
    frame(1'b1, 8'h00, 8'h00, 3'b000, "R10 thr0 back");
    normThresh = 4'd15;
    runOf(14, 8'h10, 8'h00, "R10 thr15 not yet");
    frame(1'b1, 8'h10, 8'h00, 3'b000, "R10 thr15 accept");
    maskRfi = 1'b1; maskRdi = 1'b1; maskErdi = 1'b1;
    frame(1'b0, 8'h00, 8'h00, 3'b000, "R8 all masked");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule